// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservation state that a single core needs for atomic read-modify-write sequences built from a linked load and a conditional store. A linked load raises a one-bit link flag, records which address granule it covers, and sends a reserving read of the requested size to memory. A later conditional store writes to memory only when the flag is still raised and its address falls in the recorded granule. Every conditional store returns a success word to the destination register: 1 on success, 0 on failure, zero-extended to the full register width.

The pipeline sends one request per cycle on `req_op`, together with an access size, a physical address and the store data. An exception return on the normal, non-error path pulses `eret_clear`, which drops the link. All results appear one clock after the request, as single-cycle pulses. A failed conditional store never produces a memory write.

Top module: `llsc_monitor`

## Requirements
- R1: When `req_op` is 1 (linked load), the next cycle shows `rd_valid` high, with `rd_addr` equal to the request address and `rd_bytes` equal to 1, 2, 4 or 8. From that cycle `link_active` is 1.
- R2: When `req_op` is 2 (conditional store) and the link flag is clear, the next cycle shows `rsp_valid` high, `rsp_result` equal to 0 and `wr_valid` low.
- R3: A successful conditional store pulses `wr_valid` in the next cycle. `wr_addr` is the request address. The size code `req_size` selects 0=byte, 1=half, 2=word or 3=double, and `wr_bytes` is 1, 2, 4 or 8 to match. `wr_data` holds that many low bytes of `req_wdata`, and all higher bytes are zero.
- R4: Every conditional store gives `rsp_valid` one cycle later. `rsp_result` is the 64-bit value 1 on success and 0 on failure.
- R5: `eret_clear` drops the link flag. If it comes in the same cycle as a linked load, the load wins and the flag ends up set. If it comes in the same cycle as a conditional store, that store fails.
- R6: Any conditional store clears the link flag, whether it succeeds or fails. A second conditional store with no new linked load in between therefore fails.
- R7: A conditional store succeeds only if address bits [ADDR_W-1:GRAN_LSB] equal those of the last linked load. With the default GRAN_LSB=3, a different byte in the same 8-byte granule matches, and a different granule fails.
- R8: While `rst_n` is low, and in the first cycle after it goes high, `link_active` is 0 and no valid output is high. A conditional store issued straight after reset fails.
- R9: `link_active` reports the link flag. It changes only on a linked load, a conditional store, `eret_clear` or reset.
- R10: `req_op` value 3 is reserved and does nothing. It raises no valid output and leaves `link_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_op | input | 2 | 0 idle, 1 linked load, 2 conditional store, 3 reserved |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_addr | input | ADDR_W | Physical address of the request |
| req_wdata | input | DATA_W | Source register value for a conditional store |
| eret_clear | input | 1 | Pulse from a non-error exception return |
| link_active | output | 1 | Current link flag |
| rd_valid | output | 1 | Reserving read request pulse |
| rd_addr | output | ADDR_W | Reserving read address |
| rd_bytes | output | 4 | Reserving read size in bytes |
| wr_valid | output | 1 | Conditional write request pulse |
| wr_addr | output | ADDR_W | Conditional write address |
| wr_bytes | output | 4 | Conditional write size in bytes |
| wr_data | output | DATA_W | Write data, low bytes of source, zero above |
| rsp_valid | output | 1 | Result for the destination register is valid |
| rsp_result | output | DATA_W | Zero-extended success flag |

## Verification
The conditional store is tried with the link flag clear, then raised by a load to the same address, to another byte in the same granule, and to a different granule. Together these separate the flag test from the address test and show the granule width. The four access sizes each appear on a successful store, so a wrong byte count or a data lane left unmasked shows up in `wr_data`. Back-to-back stores, exception-return pulses alone and together with a load or a store, the reserved opcode, and a reset in mid-sequence each check a different way the link can be dropped or kept.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_LINK = 2'd1,
      OP_COND = 2'd2,
      OP_RSVD = 2'd3
   } llsc_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } llsc_size_e;

   localparam int unsigned SIZE_W = 2;
   localparam int unsigned NB_W   = 4;
endpackage

// File: rtl/llsc_lane_sel.sv
module llsc_lane_sel
   import llsc_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [NB_W-1:0]   nbytes_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int unsigned LANES = DATA_W / 8;

   generate
      if (DATA_W != 64) begin : g_bad_width
         $error("llsc_lane_sel: DATA_W must be 64 for four access sizes");
      end
   endgenerate

   always_comb begin
      nbytes_o = NB_W'(1) << size_i;
   end

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         logic lane_on;
         assign lane_on = (NB_W'(gi) < nbytes_o);
         assign data_o[gi*8 +: 8] = lane_on ? data_i[gi*8 +: 8] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/llsc_link_tracker.sv
module llsc_link_tracker #(
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned GRAN_LSB = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              drop_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              link_q,
   output logic              hit_o
);
   localparam int unsigned TAG_W = ADDR_W - GRAN_LSB;

   generate
      if (GRAN_LSB >= ADDR_W) begin : g_bad_gran
         $error("llsc_link_tracker: GRAN_LSB must be below ADDR_W");
      end
   endgenerate

   logic [TAG_W-1:0] tag_q;
   logic [TAG_W-1:0] tag_in;

   assign tag_in = addr_i[ADDR_W-1:GRAN_LSB];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         tag_q  <= '0;
      end else if (set_i) begin
         link_q <= 1'b1;
         tag_q  <= tag_in;
      end else if (drop_i) begin
         link_q <= 1'b0;
      end
   end

   assign hit_o = link_q && (tag_q == tag_in);

   p_set_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> link_q);
   p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_i && !set_i) |=> !link_q);
   p_link_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !drop_i) |=> $stable(link_q));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned GRAN_LSB = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        req_op,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              eret_clear,
   output logic              link_active,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [3:0]        rd_bytes,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [3:0]        wr_bytes,
   output logic [DATA_W-1:0] wr_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_result
);
   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("llsc_monitor: ADDR_W too small");
      end
   endgenerate

   logic              is_link;
   logic              is_cond;
   logic              link_q;
   logic              tag_hit;
   logic              cond_ok;
   logic [NB_W-1:0]   nbytes;
   logic [DATA_W-1:0] lane_data;

   assign is_link = (req_op == OP_LINK);
   assign is_cond = (req_op == OP_COND);

   llsc_link_tracker #(
      .ADDR_W  (ADDR_W),
      .GRAN_LSB(GRAN_LSB)
   ) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (is_link),
      .drop_i(is_cond | eret_clear),
      .addr_i(req_addr),
      .link_q(link_q),
      .hit_o (tag_hit)
   );

   llsc_lane_sel #(
      .DATA_W(DATA_W)
   ) u_lane (
      .size_i  (req_size),
      .data_i  (req_wdata),
      .nbytes_o(nbytes),
      .data_o  (lane_data)
   );

   assign cond_ok = is_cond && tag_hit && !eret_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_addr    <= '0;
         rd_bytes   <= '0;
         wr_valid   <= 1'b0;
         wr_addr    <= '0;
         wr_bytes   <= '0;
         wr_data    <= '0;
         rsp_valid  <= 1'b0;
         rsp_result <= '0;
      end else begin
         rd_valid  <= is_link;
         wr_valid  <= cond_ok;
         rsp_valid <= is_cond;
         if (is_link) begin
            rd_addr  <= req_addr;
            rd_bytes <= nbytes;
         end
         if (cond_ok) begin
            wr_addr  <= req_addr;
            wr_bytes <= nbytes;
            wr_data  <= lane_data;
         end
         if (is_cond) begin
            rsp_result <= {{(DATA_W-1){1'b0}}, cond_ok};
         end
      end
   end

   assign link_active = link_q;

   p_unlinked_fails_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cond && !link_q) |=> (rsp_valid && !wr_valid && rsp_result == '0));
   p_write_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $onehot(wr_bytes));
   p_write_reports_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (rsp_valid && rsp_result == {{(DATA_W-1){1'b0}}, 1'b1}));
   p_eret_store_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cond && eret_clear) |=> !wr_valid);
   p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op == OP_RSVD) |=> (!rd_valid && !wr_valid && !rsp_valid));
endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
   localparam int AW = 40;
   localparam int DW = 64;
   localparam logic [63:0] SRC = 64'h1122334455667788;

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  sz;
      logic [39:0] addr;
      logic        er;
      logic        e_link;
      logic        e_rd;
      logic        e_wr;
      logic        e_rsp;
      logic        e_res;
      logic [3:0]  e_nb;
      logic [63:0] e_wd;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{2'd2, 2'd3, 40'h100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},               // R2 no link
      '{2'd1, 2'd2, 40'h100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 64'h0},               // R1
      '{2'd2, 2'd0, 40'h100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 64'h88},              // R3 byte
      '{2'd2, 2'd0, 40'h100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},               // R6 second store
      '{2'd1, 2'd3, 40'h200, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 64'h0},
      '{2'd2, 2'd1, 40'h204, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2, 64'h7788},            // R7 same granule
      '{2'd1, 2'd2, 40'h300, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 64'h0},
      '{2'd2, 2'd2, 40'h308, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},               // R7 other granule
      '{2'd1, 2'd3, 40'h400, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 64'h0},
      '{2'd0, 2'd0, 40'h400, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h0},               // R5 eret alone
      '{2'd2, 2'd3, 40'h400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},               // R5 store after eret
      '{2'd1, 2'd0, 40'h500, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 64'h0},               // R5 load wins
      '{2'd2, 2'd2, 40'h500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 64'h0},               // R5 store with eret
      '{2'd1, 2'd1, 40'h600, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 64'h0},
      '{2'd3, 2'd0, 40'h600, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 64'h0},               // R10 reserved
      '{2'd2, 2'd3, 40'h600, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8, SRC},                 // R3 double
      '{2'd1, 2'd0, 40'h700, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 64'h0},
      '{2'd2, 2'd2, 40'h700, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4, 64'h55667788}         // R3 word
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          eret_clear = 1'b0;
   logic          link_active;
   logic          rd_valid;
   logic [AW-1:0] rd_addr;
   logic [3:0]    rd_bytes;
   logic          wr_valid;
   logic [AW-1:0] wr_addr;
   logic [3:0]    wr_bytes;
   logic [DW-1:0] wr_data;
   logic          rsp_valid;
   logic [DW-1:0] rsp_result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   llsc_monitor uut (
      .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata), .eret_clear(eret_clear),
      .link_active(link_active), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_bytes(rd_bytes), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_bytes(wr_bytes), .wr_data(wr_data), .rsp_valid(rsp_valid),
      .rsp_result(rsp_result)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic er);
      @(negedge clk);
      req_op = op; req_size = sz; req_addr = a; req_wdata = SRC; eret_clear = er;
      @(posedge clk);
      #2;
      @(negedge clk);
      req_op = 2'd0; eret_clear = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R8: state during reset
      check("R8 link in reset", 64'(link_active), 64'd0);
      check("R8 valids in reset", {61'd0, rd_valid, wr_valid, rsp_valid}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check("R8 link after reset", 64'(link_active), 64'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req_op = VEC[i].op; req_size = VEC[i].sz; req_addr = VEC[i].addr;
         req_wdata = SRC; eret_clear = VEC[i].er;
         @(posedge clk);
         #2;
         check($sformatf("R9 link v%0d", i), 64'(link_active), 64'(VEC[i].e_link));
         check($sformatf("R1 rd_valid v%0d", i), 64'(rd_valid), 64'(VEC[i].e_rd));
         check($sformatf("R3 wr_valid v%0d", i), 64'(wr_valid), 64'(VEC[i].e_wr));
         check($sformatf("R4 rsp_valid v%0d", i), 64'(rsp_valid), 64'(VEC[i].e_rsp));
         if (VEC[i].e_rsp)
            check($sformatf("R4 result v%0d", i), rsp_result, 64'(VEC[i].e_res));
         if (VEC[i].e_rd) begin
            check($sformatf("R1 rd_addr v%0d", i), 64'(rd_addr), 64'(VEC[i].addr));
            check($sformatf("R1 rd_bytes v%0d", i), 64'(rd_bytes), 64'(VEC[i].e_nb));
         end
         if (VEC[i].e_wr) begin
            check($sformatf("R3 wr_addr v%0d", i), 64'(wr_addr), 64'(VEC[i].addr));
            check($sformatf("R3 wr_bytes v%0d", i), 64'(wr_bytes), 64'(VEC[i].e_nb));
            check($sformatf("R3 wr_data v%0d", i), wr_data, VEC[i].e_wd);
         end
      end

      // R8: reset in the middle of a linked sequence
      apply(2'd1, 2'd3, 40'h800, 1'b0);
      check("R8 link before mid reset", 64'(link_active), 64'd1);
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      check("R8 link in mid reset", 64'(link_active), 64'd0);
      check("R8 valids in mid reset", {61'd0, rd_valid, wr_valid, rsp_valid}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      req_op = 2'd2; req_size = 2'd3; req_addr = 40'h800; eret_clear = 1'b0;
      @(posedge clk);
      #2;
      check("R8 store after reset wr", 64'(wr_valid), 64'd0);
      check("R8 store after reset result", rsp_result, 64'd0);
      @(negedge clk);
      req_op = 2'd0;

      // R10: reserved opcode with link clear leaves it clear
      apply(2'd3, 2'd0, 40'h900, 1'b0);
      check("R10 reserved keeps link clear", 64'(link_active), 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule